// File: doc/BRIEF.md
# Prescaled Multi-Channel Match Timer

This block is a free-running up-counter with a programmable clock divider and a set of match channels. It sits behind a simple word-addressed register port. Each write is a single-cycle strobe with an address and data. Reads are combinational on the address. Software sets a divide ratio, enables counting and loads per-channel compare values. It then waits on one interrupt line, which is raised whenever any enabled channel has seen the counter reach its compare value.

A hidden divider counts input clocks and emits a tick once every `prescale + 1` clocks. The counter advances by one on each tick and wraps to zero after all ones. On the clock edge at which the counter takes a channel's compare value, that channel latches a sticky flag, provided its match-interrupt enable is set. Software clears flags by writing ones to the flag register.

The register port is a plain control path with no back-pressure. Every write strobe is accepted in the cycle it is presented. Read data reflects the addressed register in the same cycle. Register word addresses: 0 control (bit 0 = run), 1 count mode (bits 1:0), 2 prescale, 3 count (read only), 4 match control, 5 flags, 8+n match value of channel n.

Top module: `match_timer`

## Requirements
- R1: After reset the count, the divider, every register and every flag read 0, `irq` is 0 and the timer is stopped.
- R2: While counting, the count rises by exactly one once every prescale+1 clocks, counted from the edge that starts the run. The divider restarts from 0 each time it ticks, and a prescale of 0 advances the count on every clock.
- R3: Bit 0 of the control register (address 0) gates counting. Clearing it freezes both count and divider, and setting it again resumes from the held values.
- R4: The count-mode field (address 1, bits 1:0) must be 0 for counting. Any nonzero value halts the count and the divider.
- R5: The count is readable at address 3 at any time. Writes there are ignored. After all ones (width CNT_W) it wraps to 0.
- R6: The compare value of channel n is written and read back at address 8+n.
- R7: The match control register (address 4) holds a 3-bit group per channel. Bit 3n enables the match flag of channel n. The other bits are stored and read back but have no effect.
- R8: Flag n (bit n of address 5) is set on the clock edge at which the count takes channel n's compare value, and only if bit 3n of match control is 1. Once set, it stays set.
- R9: Writing a 1 to bit n of address 5 clears flag n. Writing a 0 leaves it unchanged.
- R10: `irq` is 1 exactly when at least one flag is set.
- R11: When a match and a clearing write reach the same flag on the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 4 | Register word address for read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register |
| irq | output | 1 | Interrupt, OR of all match flags |

## Verification
The bench builds the block with four channels and a 12-bit counter. The narrow counter makes the wrap from all ones to zero, and a match on the wrapped value of zero, reachable in a few thousand cycles. The default 32-bit width would put that case out of reach. Prescale, data and register widths stay at their defaults of 32 bits. The divider logic is therefore the same as in the full-width build.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int ADDR_W = 4;
  localparam int MODE_W = 2;
  localparam int GRP_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MCTL   = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd5;
  localparam int                MATCH_BASE = 8;

  typedef enum logic [MODE_W-1:0] {
    MODE_TIMER = 2'd0,
    MODE_RSV1  = 2'd1,
    MODE_RSV2  = 2'd2,
    MODE_RSV3  = 2'd3
  } count_mode_e;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int PR_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [PR_W-1:0] limit,
  output logic            tick
);
  logic [PR_W-1:0] div_q;

  // >= so a prescale lowered mid-run still ticks promptly
  assign tick = active && (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= '0;
    end else if (active) begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);
  logic [CNT_W-1:0] cnt_q;

  assign count     = cnt_q;
  assign count_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= count_nxt;
    end
  end
endmodule

// File: rtl/mt_match_chan.sv
module mt_match_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic             int_en,
  input  logic             clr,
  output logic [CNT_W-1:0] match_val,
  output logic             hit,
  output logic             flag
);
  logic [CNT_W-1:0] match_q;
  logic             flag_q;

  assign match_val = match_q;
  assign flag      = flag_q;
  assign hit       = tick && int_en && (count_nxt == match_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
    end else if (load) begin
      match_q <= load_val;
    end
  end

  // a new match has priority over a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PR_W   = 32,
  parameter int N_CH   = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [match_timer_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic                          irq
);
  localparam int MCTL_W = GRP_W * N_CH;

  logic              run_q;
  count_mode_e       mode_q;
  logic [PR_W-1:0]   presc_q;
  logic [MCTL_W-1:0] mctl_q;

  logic              tick;
  logic              active;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  count_nxt;

  logic [N_CH-1:0]   ie_vec;
  logic [N_CH-1:0]   clr_vec;
  logic [N_CH-1:0]   hit_vec;
  logic [N_CH-1:0]   flag_vec;
  logic [CNT_W-1:0]  match_arr [N_CH];

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode_q  <= MODE_TIMER;
      presc_q <= '0;
      mctl_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  run_q   <= wdata[0];
        A_MODE:  mode_q  <= count_mode_e'(wdata[MODE_W-1:0]);
        A_PRESC: presc_q <= wdata[PR_W-1:0];
        A_MCTL:  mctl_q  <= wdata[MCTL_W-1:0];
        default: ;
      endcase
    end
  end

  assign active  = run_q && (mode_q == MODE_TIMER);
  assign clr_vec = (wr_en && addr == A_FLAGS) ? wdata[N_CH-1:0] : '0;

  mt_prescaler #(.PR_W(PR_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .limit  (presc_q),
    .tick   (tick)
  );

  mt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .count     (count),
    .count_nxt (count_nxt)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic ld;
    assign ie_vec[g] = mctl_q[GRP_W*g];
    assign ld        = wr_en && (addr == ADDR_W'(MATCH_BASE + g));

    mt_match_chan #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_val  (wdata[CNT_W-1:0]),
      .tick      (tick),
      .count_nxt (count_nxt),
      .int_en    (ie_vec[g]),
      .clr       (clr_vec[g]),
      .match_val (match_arr[g]),
      .hit       (hit_vec[g]),
      .flag      (flag_vec[g])
    );
  end

  assign irq = |flag_vec;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = DATA_W'(run_q);
      A_MODE:  rdata = DATA_W'(mode_q);
      A_PRESC: rdata = DATA_W'(presc_q);
      A_COUNT: rdata = DATA_W'(count);
      A_MCTL:  rdata = DATA_W'(mctl_q);
      A_FLAGS: rdata = DATA_W'(flag_vec);
      default: begin
        for (int i = 0; i < N_CH; i++) begin
          if (addr == ADDR_W'(MATCH_BASE + i)) rdata = DATA_W'(match_arr[i]);
        end
      end
    endcase
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [N_CH-1:0]  ie,
  input logic [N_CH-1:0]  clr,
  input logic [N_CH-1:0]  hit,
  input logic [N_CH-1:0]  flags
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt)); // R3

  AST_MODE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> $stable(cnt)); // R4

  AST_NO_FLAG_WITHOUT_IE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(ie)) == '0)); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(clr) & ~$past(hit)) == '0)); // R9

  AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(hit)) == $past(hit))); // R11
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run_q),
  .mode  (mode_q),
  .cnt   (count),
  .ie    (ie_vec),
  .clr   (clr_vec),
  .hit   (hit_vec),
  .flags (flag_vec)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  import match_timer_pkg::*;

  localparam int CW = 12;
  localparam int NC = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  match_timer #(.CNT_W(CW), .N_CH(NC), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // prescale, wait cycles, expected count
  localparam logic [31:0] VEC [5][3] = '{
    '{32'd0, 32'd9,  32'd10},
    '{32'd1, 32'd9,  32'd5},
    '{32'd2, 32'd10, 32'd3},
    '{32'd3, 32'd2,  32'd0},
    '{32'd4, 32'd14, 32'd3}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    do_reset();

    // R1 reset state
    rd(A_COUNT, v); check("R1 count", v, 0);
    rd(A_CTRL, v);  check("R1 ctrl", v, 0);
    rd(A_FLAGS, v); check("R1 flags", v, 0);
    rd(A_PRESC, v); check("R1 presc", v, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R2 prescale table
    for (int i = 0; i < 5; i++) begin
      do_reset();
      wr(A_PRESC, VEC[i][0]);
      wr(A_CTRL, 1);
      repeat (int'(VEC[i][1])) @(negedge clk);
      wr(A_CTRL, 0);
      rd(A_COUNT, v); check("R2 prescale", v, VEC[i][2]);
    end

    // R3 freeze and resume
    do_reset();
    wr(A_CTRL, 1);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 0);
    repeat (6) @(negedge clk);
    rd(A_COUNT, v); check("R3 frozen", v, 5);
    wr(A_CTRL, 1);
    repeat (2) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_COUNT, v); check("R3 resumed", v, 8);

    // R5 count writes ignored
    wr(A_COUNT, 32'h55);
    rd(A_COUNT, v); check("R5 write ignored", v, 8);

    // R4 nonzero mode halts
    do_reset();
    wr(A_MODE, 1);
    wr(A_CTRL, 1);
    repeat (10) @(negedge clk);
    rd(A_COUNT, v); check("R4 halted", v, 0);

    // R6 R7 R8 R10 flags
    do_reset();
    wr(A_MATCH0_ADDR(0), 5);
    wr(A_MATCH0_ADDR(1), 3);
    wr(A_MATCH0_ADDR(2), 7);
    wr(A_MCTL, 32'h51); // ch0 bit0, ch2 bit6, bit4 stored only
    rd(A_MATCH0_ADDR(2), v); check("R6 match readback", v, 7);
    rd(A_MCTL, v); check("R7 mctl readback", v, 32'h51);
    wr(A_CTRL, 1);
    repeat (4) @(negedge clk);
    check("R8 before match", {31'd0, irq}, 0);
    @(negedge clk);
    check("R10 irq on match", {31'd0, irq}, 1);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_COUNT, v); check("R8 count", v, 9);
    rd(A_FLAGS, v); check("R8 R7 flags", v, 32'h5);

    // R9 write-one-to-clear
    wr(A_FLAGS, 0);
    rd(A_FLAGS, v); check("R9 zero write", v, 32'h5);
    wr(A_FLAGS, 1);
    rd(A_FLAGS, v); check("R9 clear bit0", v, 32'h4);
    check("R10 irq still", {31'd0, irq}, 1);
    wr(A_FLAGS, 4);
    rd(A_FLAGS, v); check("R9 clear bit2", v, 0);
    check("R10 irq low", {31'd0, irq}, 0);

    // R11 match and clear on the same edge
    do_reset();
    wr(A_MATCH0_ADDR(0), 6);
    wr(A_MCTL, 1);
    wr(A_CTRL, 1);
    repeat (5) @(negedge clk);
    wr(A_FLAGS, 1);
    rd(A_FLAGS, v); check("R11 match wins", v, 1);

    // R5 wrap and match on zero
    do_reset();
    wr(A_MATCH0_ADDR(3), 0);
    wr(A_MCTL, 32'h200);
    wr(A_CTRL, 1);
    repeat (4098) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_COUNT, v); check("R5 wrap", v, 3);
    rd(A_FLAGS, v); check("R8 wrap match", v, 32'h8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [3:0] A_MATCH0_ADDR(input int ch);
    return 4'(MATCH_BASE + ch);
  endfunction
endmodule